// File: doc/BRIEF.md
# CAN Receive Message Ring

This block is the storage stage behind a CAN receiver. It holds received messages as variable-length records in a 64-byte circular byte store. A record is 3 to 13 bytes long. It holds a frame-information byte, then two identifier bytes for a standard frame or four for an extended frame, then the data bytes. The receiver pushes bytes one at a time, marks the first byte of each message, and closes the message with a commit or an abort. The block works out how long each record must be from its frame-information byte. Only complete records become visible to the host.

The host reads the oldest stored message through a 13-byte window. Byte 0 of the window is at the start address, and the window wraps at the end of the store. A release command drops the oldest message: the start address moves past it and the message count falls by one. If the ring runs out of space while a message is being written, that message is rolled back and a sticky overrun status is raised. While the configuration hold input is high, all state is cleared.

The byte input is a valid-only stream with no back-pressure. The block accepts every presented byte in the cycle it appears. When there is no room, it reports the lost message through the overrun signals; it never stalls the sender. The window port is a plain combinational read.

Top module: `can_rx_ring`

## Requirements
- R1: After `rst_n` is deasserted, `start_addr_o` is 0, `msg_count_o` is 0, `not_empty_o` is 0, `ovr_status_o` is 0 and `ovr_pulse_o` is 0.
- R2: `win_data_o` returns the stored byte at address (`start_addr_o` + `win_addr_i`) mod 64 for `win_addr_i` from 0 to 12. It returns 0 for `win_addr_i` from 13 to 15.
- R3: A record's length is 1 + (4 if info bit 7 is set, else 2) + (0 if info bit 6 is set, else min(info bits 3..0, 8)). Bytes that the receiver presents beyond that length are not stored.
- R4: A commit with `wr_valid_i` low adds one to `msg_count_o`, but only when all the bytes of the current record have been received. A commit on a shorter record discards it, frees its space, and leaves the count unchanged. The count never rises without a commit.
- R5: A release while `msg_count_o` is not 0 advances `start_addr_o` by the head record's length (mod 64) and reduces the count by one. A release with a count of 0 changes nothing.
- R6: `not_empty_o` is 1 exactly while `msg_count_o` is not 0. This holds in the cycle after a release, whether or not messages remain.
- R7: A stored-length byte that arrives when all 64 bytes are taken triggers an overrun. The byte counts whether it is a first byte or a later byte. On overrun, the current record is discarded, `ovr_status_o` is set, `ovr_pulse_o` is high for one cycle, and the messages already committed stay intact. Any later non-first bytes and the commit for that record are ignored.
- R8: `ovr_status_o` stays set until a cycle with `clr_ovr_i` high clears it. If an overrun and a clear fall in the same cycle, the overrun wins.
- R9: After an abort or an overrun, the next record is written starting at the first byte of the dropped record, so no space is lost.
- R10: While `hold_i` is high, the count, start address, write position and overrun state go to 0 and incoming bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Configuration hold; clears the ring while high |
| wr_valid_i | input | 1 | A received byte is presented on `wr_data_i` |
| wr_sof_i | input | 1 | With `wr_valid_i`: the byte is the frame-information byte of a new record |
| wr_data_i | input | 8 | Received byte |
| wr_commit_i | input | 1 | Close the current record as complete (honoured only when `wr_valid_i` is low) |
| wr_abort_i | input | 1 | Drop the current record (honoured only when `wr_valid_i` is low) |
| win_addr_i | input | 4 | Window byte index |
| win_data_o | output | 8 | Window byte read data |
| release_i | input | 1 | Release the oldest record |
| clr_ovr_i | input | 1 | Clear the overrun status |
| start_addr_o | output | 6 | Ring address of the oldest record |
| msg_count_o | output | 5 | Number of committed records stored |
| not_empty_o | output | 1 | At least one record is stored |
| ovr_status_o | output | 1 | Sticky overrun status |
| ovr_pulse_o | output | 1 | One-cycle pulse on each overrun |

## Verification
The assertions assume that commit and abort are only ever requested in cycles with no byte presented, and that every record starts with a byte flagged as first. Release is assumed to arrive as a single-cycle request. The directed stimulus drives each byte, commit, abort, release and clear as its own one-cycle event, and it always opens a record with a first-byte flag. This keeps the stimulus within those rules. Overrun is reached both on a first byte and in the middle of a record, against a ring that is exactly full and one that is partly full.

// File: rtl/can_rx_ring_pkg.sv
package can_rx_ring_pkg;

  localparam int LEN_W = 4;

  // Record length from its frame-information byte:
  // info byte + identifier bytes + capped data bytes (none for a remote frame).
  function automatic logic [LEN_W-1:0] rec_len(input logic [7:0] info, input int unsigned cap);
    int unsigned n_id;
    int unsigned n_data;
    n_id   = info[7] ? 4 : 2;
    n_data = 0;
    if (!info[6]) begin
      n_data = (int'(info[3:0]) > int'(cap)) ? cap : int'(info[3:0]);
    end
    return LEN_W'(1 + n_id + n_data);
  endfunction

endpackage

// File: rtl/rxr_store.sv
module rxr_store #(
  parameter int ADDR_W    = 6,
  parameter int WIN_BYTES = 13,
  parameter int WA_W      = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic [WA_W-1:0]   win_addr,
  output logic [7:0]        win_data,
  output logic [7:0]        head_info
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [ADDR_W-1:0] win_idx;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    win_idx  = head_ptr + ADDR_W'(win_addr);
    win_data = (int'(win_addr) < WIN_BYTES) ? mem[win_idx] : 8'h00;
    head_info = mem[head_ptr];
  end

endmodule

// File: rtl/rxr_writer.sv
module rxr_writer #(
  parameter int ADDR_W   = 6,
  parameter int MAX_DATA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_valid,
  input  logic              wr_sof,
  input  logic [7:0]        wr_data,
  input  logic              wr_commit,
  input  logic              wr_abort,
  input  logic [ADDR_W:0]   fill,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              commit_fire,
  output logic [can_rx_ring_pkg::LEN_W-1:0] commit_len,
  output logic              ovr_fire
);

  import can_rx_ring_pkg::*;

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FILL_W = ADDR_W + 1;

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  cur;
  logic [LEN_W-1:0]  exp_len;

  logic [FILL_W:0] used_now;
  logic            room_first;
  logic            room_next;
  logic            take_first;
  logic            take_next;
  logic            ctl_cycle;

  always_comb begin
    used_now   = {1'b0, fill} + (FILL_W + 1)'(cur);
    room_first = int'(fill) < DEPTH;
    room_next  = int'(used_now) < DEPTH;
    take_first = wr_valid && wr_sof;
    take_next  = wr_valid && !wr_sof && active && (cur < exp_len);
    ctl_cycle  = !wr_valid && active;

    ovr_fire    = !hold && ((take_first && !room_first) || (take_next && !room_next));
    mem_we      = !hold && ((take_first && room_first) || (take_next && room_next));
    mem_waddr   = take_first ? base : base + ADDR_W'(cur);
    mem_wdata   = wr_data;
    commit_fire = !hold && ctl_cycle && wr_commit && (cur == exp_len);
    commit_len  = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base    <= '0;
      cur     <= '0;
      exp_len <= '0;
    end else if (hold) begin
      active  <= 1'b0;
      base    <= '0;
      cur     <= '0;
      exp_len <= '0;
    end else if (ovr_fire) begin
      active <= 1'b0;
      cur    <= '0;
    end else if (take_first) begin
      active  <= 1'b1;
      cur     <= LEN_W'(1);
      exp_len <= rec_len(wr_data, MAX_DATA);
    end else if (take_next) begin
      cur <= cur + LEN_W'(1);
    end else if (ctl_cycle && (wr_commit || wr_abort)) begin
      if (commit_fire) begin
        base <= base + ADDR_W'(cur);
      end
      active <= 1'b0;
      cur    <= '0;
    end
  end

endmodule

// File: rtl/rxr_ledger.sv
module rxr_ledger #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              commit_fire,
  input  logic [can_rx_ring_pkg::LEN_W-1:0] commit_len,
  input  logic              release_req,
  input  logic [can_rx_ring_pkg::LEN_W-1:0] head_len,
  input  logic              ovr_fire,
  input  logic              clr_ovr,
  output logic              rel_fire,
  output logic [ADDR_W:0]   fill,
  output logic [CNT_W-1:0]  count,
  output logic              ovr_status,
  output logic              ovr_pulse
);

  localparam int FILL_W = ADDR_W + 1;

  logic [FILL_W-1:0] fill_add;
  logic [FILL_W-1:0] fill_sub;

  always_comb begin
    rel_fire = !hold && release_req && (count != '0);
    fill_add = commit_fire ? FILL_W'(commit_len) : '0;
    fill_sub = rel_fire ? FILL_W'(head_len) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill       <= '0;
      count      <= '0;
      ovr_status <= 1'b0;
      ovr_pulse  <= 1'b0;
    end else if (hold) begin
      fill       <= '0;
      count      <= '0;
      ovr_status <= 1'b0;
      ovr_pulse  <= 1'b0;
    end else begin
      fill <= fill + fill_add - fill_sub;
      case ({commit_fire, rel_fire})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      ovr_pulse <= ovr_fire;
      if (ovr_fire) begin
        ovr_status <= 1'b1;
      end else if (clr_ovr) begin
        ovr_status <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxr_head.sv
module rxr_head #(
  parameter int ADDR_W   = 6,
  parameter int MAX_DATA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              rel_fire,
  input  logic [7:0]        head_info,
  output logic [ADDR_W-1:0] head_ptr,
  output logic [can_rx_ring_pkg::LEN_W-1:0] head_len
);

  import can_rx_ring_pkg::*;

  assign head_len = rec_len(head_info, MAX_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
    end else if (hold) begin
      head_ptr <= '0;
    end else if (rel_fire) begin
      head_ptr <= head_ptr + ADDR_W'(head_len);
    end
  end

endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring #(
  parameter int ADDR_W    = 6,
  parameter int WIN_BYTES = 13,
  parameter int MAX_DATA  = 8,
  parameter int CNT_W     = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hold_i,
  input  logic                         wr_valid_i,
  input  logic                         wr_sof_i,
  input  logic [7:0]                   wr_data_i,
  input  logic                         wr_commit_i,
  input  logic                         wr_abort_i,
  input  logic [$clog2(WIN_BYTES)-1:0] win_addr_i,
  output logic [7:0]                   win_data_o,
  input  logic                         release_i,
  input  logic                         clr_ovr_i,
  output logic [ADDR_W-1:0]            start_addr_o,
  output logic [CNT_W-1:0]             msg_count_o,
  output logic                         not_empty_o,
  output logic                         ovr_status_o,
  output logic                         ovr_pulse_o
);

  import can_rx_ring_pkg::*;

  localparam int WA_W = $clog2(WIN_BYTES);

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [7:0]        head_info;
  logic [ADDR_W-1:0] head_ptr;
  logic [LEN_W-1:0]  head_len;
  logic              commit_fire;
  logic [LEN_W-1:0]  commit_len;
  logic              ovr_fire;
  logic              rel_fire;
  logic [ADDR_W:0]   fill;
  logic [CNT_W-1:0]  count;

  rxr_store #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .WA_W(WA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .head_ptr(head_ptr), .win_addr(win_addr_i), .win_data(win_data_o),
    .head_info(head_info)
  );

  rxr_writer #(.ADDR_W(ADDR_W), .MAX_DATA(MAX_DATA)) u_writer (
    .clk(clk), .rst_n(rst_n), .hold(hold_i),
    .wr_valid(wr_valid_i), .wr_sof(wr_sof_i), .wr_data(wr_data_i),
    .wr_commit(wr_commit_i), .wr_abort(wr_abort_i), .fill(fill),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .commit_fire(commit_fire), .commit_len(commit_len), .ovr_fire(ovr_fire)
  );

  rxr_ledger #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .hold(hold_i),
    .commit_fire(commit_fire), .commit_len(commit_len),
    .release_req(release_i), .head_len(head_len),
    .ovr_fire(ovr_fire), .clr_ovr(clr_ovr_i),
    .rel_fire(rel_fire), .fill(fill), .count(count),
    .ovr_status(ovr_status_o), .ovr_pulse(ovr_pulse_o)
  );

  rxr_head #(.ADDR_W(ADDR_W), .MAX_DATA(MAX_DATA)) u_head (
    .clk(clk), .rst_n(rst_n), .hold(hold_i), .rel_fire(rel_fire),
    .head_info(head_info), .head_ptr(head_ptr), .head_len(head_len)
  );

  assign start_addr_o = head_ptr;
  assign msg_count_o  = count;
  assign not_empty_o  = (count != '0);

endmodule

// File: rtl/can_rx_ring_chk.sv
module can_rx_ring_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_i,
  input logic              wr_commit_i,
  input logic              release_i,
  input logic              clr_ovr_i,
  input logic [ADDR_W-1:0] start_addr_o,
  input logic [CNT_W-1:0]  msg_count_o,
  input logic              not_empty_o,
  input logic              ovr_status_o,
  input logic              ovr_pulse_o
);

  assert_count_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit_i |=> (msg_count_o <= $past(msg_count_o)));

  assert_release_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && msg_count_o != '0 && !hold_i) |=> (start_addr_o != $past(start_addr_o)));

  assert_release_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && msg_count_o == '0 && !hold_i) |=> $stable(start_addr_o));

  assert_last_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && msg_count_o == CNT_W'(1) && !wr_commit_i && !hold_i) |=> !not_empty_o);

  assert_pulse_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse_o |-> ovr_status_o);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_status_o && !clr_ovr_i && !hold_i) |=> ovr_status_o);

  assert_hold_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (msg_count_o == '0 && start_addr_o == '0 && !ovr_status_o && !ovr_pulse_o));

endmodule

bind can_rx_ring can_rx_ring_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .wr_commit_i(wr_commit_i),
  .release_i(release_i), .clr_ovr_i(clr_ovr_i), .start_addr_o(start_addr_o),
  .msg_count_o(msg_count_o), .not_empty_o(not_empty_o),
  .ovr_status_o(ovr_status_o), .ovr_pulse_o(ovr_pulse_o)
);

// File: tb/sim_can_rx_ring.sv
`timescale 1ns/1ps
module sim_can_rx_ring;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic       wr_sof_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       wr_commit_i = 1'b0;
  logic       wr_abort_i = 1'b0;
  logic [3:0] win_addr_i = 4'h0;
  logic [7:0] win_data_o;
  logic       release_i = 1'b0;
  logic       clr_ovr_i = 1'b0;
  logic [5:0] start_addr_o;
  logic [4:0] msg_count_o;
  logic       not_empty_o;
  logic       ovr_status_o;
  logic       ovr_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_ring u0 (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
    .wr_valid_i(wr_valid_i), .wr_sof_i(wr_sof_i), .wr_data_i(wr_data_i),
    .wr_commit_i(wr_commit_i), .wr_abort_i(wr_abort_i),
    .win_addr_i(win_addr_i), .win_data_o(win_data_o),
    .release_i(release_i), .clr_ovr_i(clr_ovr_i),
    .start_addr_o(start_addr_o), .msg_count_o(msg_count_o),
    .not_empty_o(not_empty_o), .ovr_status_o(ovr_status_o),
    .ovr_pulse_o(ovr_pulse_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input bit sof, input logic [7:0] d);
    wr_valid_i = 1'b1; wr_sof_i = sof; wr_data_i = d;
    tick();
    wr_valid_i = 1'b0; wr_sof_i = 1'b0;
  endtask

  task automatic do_commit(); wr_commit_i = 1'b1; tick(); wr_commit_i = 1'b0; endtask
  task automatic do_abort();  wr_abort_i = 1'b1;  tick(); wr_abort_i = 1'b0;  endtask
  task automatic do_release(); release_i = 1'b1; tick(); release_i = 1'b0; endtask
  task automatic do_clear();  hold_i = 1'b1; tick(); hold_i = 1'b0; endtask

  // Byte k (k >= 1) of a message carries seed + k. close: 0 none, 1 commit, 2 abort.
  task automatic msg(input bit ide, input bit rtr, input logic [3:0] dlc,
                     input int ndata, input int close, input logic [7:0] seed);
    int nid;
    nid = ide ? 4 : 2;
    put(1'b1, {ide, rtr, 2'b00, dlc});
    for (int k = 1; k <= nid + ndata; k++) put(1'b0, seed + 8'(k));
    if (close == 1) do_commit();
    if (close == 2) do_abort();
  endtask

  task automatic win(input int a, output int v);
    win_addr_i = 4'(a);
    #1;
    v = int'(win_data_o);
  endtask

  task automatic chk_win(input string req, input int a, input int exp);
    int v;
    win(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 start", int'(start_addr_o), 0);
    chk("R1 count", int'(msg_count_o), 0);
    chk("R1 not_empty", int'(not_empty_o), 0);
    chk("R1 ovr_status", int'(ovr_status_o), 0);
    chk("R1 ovr_pulse", int'(ovr_pulse_o), 0);
  endtask

  task automatic t_basic();
    do_clear();
    msg(1'b0, 1'b0, 4'd3, 3, 1, 8'h10);
    chk("R4 count after commit", int'(msg_count_o), 1);
    chk("R6 not_empty", int'(not_empty_o), 1);
    chk_win("R2 win0 info", 0, 8'h03);
    chk_win("R2 win1", 1, 8'h11);
    chk_win("R2 win5", 5, 8'h15);
    chk_win("R2 win13 zero", 13, 0);
    chk_win("R2 win15 zero", 15, 0);
  endtask

  task automatic t_cap();
    do_clear();
    msg(1'b1, 1'b0, 4'd15, 12, 1, 8'h40);
    msg(1'b0, 1'b0, 4'd0, 0, 1, 8'h60);
    chk("R4 two messages", int'(msg_count_o), 2);
    chk_win("R3 last stored data byte", 12, 8'h4C);
    do_release();
    chk("R5 start after 13-byte record", int'(start_addr_o), 13);
    chk("R5 count after release", int'(msg_count_o), 1);
    chk("R6 not_empty stays", int'(not_empty_o), 1);
    chk_win("R3 excess data not stored", 1, 8'h61);
  endtask

  task automatic t_rtr();
    do_clear();
    msg(1'b0, 1'b1, 4'd5, 5, 1, 8'h20);
    msg(1'b0, 1'b0, 4'd1, 1, 1, 8'h30);
    do_release();
    chk("R3 remote record length", int'(start_addr_o), 3);
    chk_win("R3 next record info", 0, 8'h01);
    chk_win("R2 next record data", 3, 8'h33);
    do_release();
    chk("R5 start after last", int'(start_addr_o), 7);
    chk("R6 not_empty drops", int'(not_empty_o), 0);
    do_release();
    chk("R5 empty release start", int'(start_addr_o), 7);
    chk("R5 empty release count", int'(msg_count_o), 0);
  endtask

  task automatic t_short();
    do_clear();
    msg(1'b0, 1'b0, 4'd4, 2, 1, 8'h50);
    chk("R4 short commit dropped", int'(msg_count_o), 0);
    msg(1'b0, 1'b0, 4'd0, 0, 1, 8'h70);
    chk("R4 count after good commit", int'(msg_count_o), 1);
    chk_win("R4 space recovered", 1, 8'h71);
  endtask

  task automatic t_abort();
    do_clear();
    msg(1'b1, 1'b0, 4'd2, 1, 2, 8'h90);
    chk("R9 abort count", int'(msg_count_o), 0);
    msg(1'b0, 1'b0, 4'd1, 1, 1, 8'h80);
    chk("R9 abort count after", int'(msg_count_o), 1);
    chk_win("R9 rewrite at base info", 0, 8'h01);
    chk_win("R9 rewrite at base data", 3, 8'h83);
  endtask

  task automatic t_overflow();
    do_clear();
    for (int i = 0; i < 4; i++) msg(1'b1, 1'b0, 4'd8, 8, 1, 8'(8'h10 * (i + 1)));
    msg(1'b1, 1'b0, 4'd7, 7, 1, 8'hA0);
    chk("R7 ring full count", int'(msg_count_o), 5);
    chk("R7 no overrun yet", int'(ovr_status_o), 0);
    put(1'b1, 8'h02);
    chk("R7 pulse on full", int'(ovr_pulse_o), 1);
    chk("R7 status set", int'(ovr_status_o), 1);
    put(1'b0, 8'h11);
    chk("R7 pulse one cycle", int'(ovr_pulse_o), 0);
    put(1'b0, 8'h12);
    do_commit();
    chk("R7 dropped record not counted", int'(msg_count_o), 5);
    chk_win("R7 old data intact", 0, 8'h88);
    do_release();
    chk("R8 status sticky", int'(ovr_status_o), 1);
    msg(1'b0, 1'b1, 4'd0, 0, 1, 8'hB0);
    msg(1'b1, 1'b0, 4'd8, 8, 1, 8'hC0);
    chk("R7 mid-record overflow count", int'(msg_count_o), 5);
    msg(1'b0, 1'b1, 4'd0, 0, 1, 8'hD0);
    chk("R9 count after rollback", int'(msg_count_o), 6);
    for (int i = 0; i < 4; i++) do_release();
    chk("R5 start wraps", int'(start_addr_o), 0);
    chk_win("R2 wrapped record", 1, 8'hB1);
    do_release();
    chk_win("R9 rolled-back space reused", 1, 8'hD1);
    chk("R8 still set before clear", int'(ovr_status_o), 1);
    clr_ovr_i = 1'b1; tick(); clr_ovr_i = 1'b0;
    chk("R8 cleared by command", int'(ovr_status_o), 0);
  endtask

  task automatic t_wrap();
    do_clear();
    for (int i = 0; i < 4; i++) msg(1'b1, 1'b0, 4'd8, 8, 1, 8'h10);
    for (int i = 0; i < 4; i++) do_release();
    chk("R5 start at 52", int'(start_addr_o), 52);
    msg(1'b1, 1'b0, 4'd8, 8, 1, 8'hE0);
    chk_win("R2 window end byte 11", 11, 8'hEB);
    chk_win("R2 window wraps to 0", 12, 8'hEC);
    do_release();
    chk("R5 start wraps to 1", int'(start_addr_o), 1);
  endtask

  task automatic t_hold();
    do_clear();
    msg(1'b0, 1'b0, 4'd0, 0, 1, 8'h05);
    hold_i = 1'b1;
    msg(1'b0, 1'b0, 4'd2, 2, 1, 8'h33);
    chk("R10 count held", int'(msg_count_o), 0);
    chk("R10 start held", int'(start_addr_o), 0);
    hold_i = 1'b0;
    tick();
    chk("R10 not_empty after hold", int'(not_empty_o), 0);
    msg(1'b0, 1'b0, 4'd0, 0, 1, 8'h44);
    chk_win("R10 write position reset", 1, 8'h45);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_cap();
    t_rtr();
    t_short();
    t_abort();
    t_overflow();
    t_wrap();
    t_hold();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule